// File: doc/BRIEF.md
# Dual-Channel Timer Input Capture

This block timestamps external events against an 8-bit free-running counter. The counter advances on a tick taken from the system clock divided by 1, 2, 4 or 8. Each of two channels watches its own pin and stores the counter value when the selected edge arrives. Each channel then sets a flag. An overflow flag marks every wrap of the counter, so software can extend intervals past 256 counts.

Software uses a small register bus with a combinational read port and a single-cycle write strobe. A capture or overflow flag is cleared in two steps. The first is a status read while the flag is set. The second is a later access to the matching data register. One enable covers both capture channels. A second enable covers overflow. A global mask input holds back the combined interrupt without losing the pending request. When the mode input reports PWM or one-pulse operation, channel A is ignored and only channel B captures.

Top module: `dual_capture_timer`

## Requirements
- R1: The counter increases by one on every tick and wraps from FFh to 00h. With clock-select value s (control bits 5:4), a tick occurs once every 2^s clock cycles, so any 16-cycle window holds exactly 16>>s increments.
- R2: With its edge bit at 1, a channel captures on a rising pin edge. Each pin passes through two synchronizer flops and one edge-detect flop. With divide-by-1, the stored value is the counter value read in the cycle in which the pin changes, plus 2. The capture also sets the channel's status flag.
- R3: With its edge bit at 0, a channel captures on a falling edge, and a rising edge neither sets its flag nor changes its register.
- R4: A later capture overwrites the capture register, so it always holds the most recent event's value.
- R5: A capture flag clears only after a status read made while it is set, followed by a read or a write of that channel's capture register. An access to the register without that prior status read leaves the flag set.
- R6: If a capture and the clearing access to the same channel fall in the same cycle, the flag stays set.
- R7: timerIrq is high exactly when intMask is low and either (a capture flag is set with control bit 2 set) or (the overflow flag is set with control bit 3 set). A request held off by intMask appears as soon as intMask falls.
- R8: The overflow flag (status bit 2) sets when the counter wraps. It clears after a status read made while it is set, followed by a read of the counter register.
- R9: While altMode is high, channel A's edges are ignored and its flag stays clear, while channel B still captures.
- R10: After reset, the control, status and both capture registers read 0 and timerIrq is low.
- R11: The register map is: address 0 control (read/write), address 1 status (read only), address 2 capture A, address 3 capture B, address 4 counter. The control bits are bit 0 = edge A, bit 1 = edge B, bit 2 = capture interrupt enable, bit 3 = overflow interrupt enable, bits 5:4 = clock select. The upper control bits read 0. The status bits are bit 0 = flag A, bit 1 = flag B, bit 2 = overflow. rdData is 0 when rdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinA | input | 1 | Capture channel A event pin |
| pinB | input | 1 | Capture channel B event pin |
| altMode | input | 1 | High while PWM or one-pulse operation is active |
| intMask | input | 1 | Global interrupt mask, high blocks timerIrq |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| addr | input | 3 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the cycle of rdEn |
| timerIrq | output | 1 | Combined timer interrupt request |

## Verification
Several rules are checked by the assertions on every cycle. A flag may only fall after the arming status read and the register access. A flag is always set after a capture. A capture register changes only on a capture event, and then to the counter value of the detection cycle. The counter returns to zero after an overflow event. No channel A flag rises under altMode. The masked interrupt never fires. The bench scenarios cover what needs a known history: the exact captured value against a counter read in the same cycle, the tick rate for each clock select, ignored opposite edges, the collision of a capture with a clearing access, and an overflow that stays pending behind the mask.

// File: rtl/capt_pkg.sv
package capt_pkg;
  localparam int CNT_W  = 8;
  localparam int SEL_W  = 2;
  localparam int PRE_W  = (1 << SEL_W) - 1;
  localparam int ADDR_W = 3;
  localparam int NCH    = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_CAPA = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAPB = 3'd3;
  localparam logic [ADDR_W-1:0] A_CNT  = 3'd4;

  typedef struct packed {
    logic [SEL_W-1:0] clkSel;
    logic [NCH-1:0]   riseSel;
    logic [NCH-1:0]   chanEn;
  } dpCtl_t;
endpackage

// File: rtl/cap_edge_det.sv
module cap_edge_det (
  input  logic clk,
  input  logic rstN,
  input  logic pin,
  input  logic riseSel,
  input  logic enable,
  output logic hit
);
  logic syncA, syncB, prevVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA   <= 1'b0;
      syncB   <= 1'b0;
      prevVal <= 1'b0;
    end else begin
      syncA   <= pin;
      syncB   <= syncA;
      prevVal <= syncB;
    end
  end

  always_comb begin
    if (riseSel) hit = enable & syncB & ~prevVal;
    else         hit = enable & ~syncB & prevVal;
  end
endmodule

// File: rtl/cap_datapath.sv
module cap_datapath
  import capt_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NCH-1:0]            pins,
  input  dpCtl_t                    ctl,
  output logic [CNT_W-1:0]          cnt,
  output logic [NCH-1:0][CNT_W-1:0] capReg,
  output logic [NCH-1:0]            capEvt,
  output logic                      ovfEvt
);
  logic [PRE_W-1:0] presc;
  logic [PRE_W-1:0] divMask;
  logic             tick;

  always_comb begin
    divMask = PRE_W'((1 << ctl.clkSel) - 1);
    tick    = (presc & divMask) == divMask;
    ovfEvt  = tick && (cnt == {CNT_W{1'b1}});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc <= '0;
      cnt   <= '0;
    end else begin
      presc <= presc + 1'b1;
      if (tick) cnt <= cnt + 1'b1;
    end
  end

  // R1
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(ovfEvt) |-> cnt == '0);

  for (genvar g = 0; g < NCH; g++) begin : gChan
    cap_edge_det uEdge (
      .clk     (clk),
      .rstN    (rstN),
      .pin     (pins[g]),
      .riseSel (ctl.riseSel[g]),
      .enable  (ctl.chanEn[g]),
      .hit     (capEvt[g])
    );

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          capReg[g] <= '0;
      else if (capEvt[g]) capReg[g] <= cnt;
    end

    // R2
    cap_value_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(capEvt[g]) |-> capReg[g] == $past(cnt));
    // R4
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      (capReg[g] != $past(capReg[g])) |-> $past(capEvt[g]));
  end
endmodule

// File: rtl/cap_ctrl.sv
module cap_ctrl
  import capt_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      rdEn,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [CNT_W-1:0]          wrData,
  input  logic                      altMode,
  input  logic                      intMask,
  input  logic [CNT_W-1:0]          cnt,
  input  logic [NCH-1:0][CNT_W-1:0] capReg,
  input  logic [NCH-1:0]            capEvt,
  input  logic                      ovfEvt,
  output dpCtl_t                    dpCtl,
  output logic [CNT_W-1:0]          rdData,
  output logic                      irq
);
  localparam int CTRL_W = NCH + 2 + SEL_W;

  logic [CTRL_W-1:0] ctrlReg;
  logic [NCH-1:0]    flag, armed, capAcc;
  logic              ovfFlag, ovfArmed;
  logic              statRd, cntRd, capIe, ovfIe;

  always_comb begin
    capIe  = ctrlReg[NCH];
    ovfIe  = ctrlReg[NCH+1];
    statRd = rdEn && addr == A_STAT;
    cntRd  = rdEn && addr == A_CNT;
    capAcc[0] = (rdEn || wrEn) && addr == A_CAPA;
    capAcc[1] = (rdEn || wrEn) && addr == A_CAPB;
    dpCtl.clkSel  = ctrlReg[CTRL_W-1 -: SEL_W];
    dpCtl.riseSel = ctrlReg[NCH-1:0];
    dpCtl.chanEn  = {1'b1, ~altMode};
    irq = ~intMask & ((capIe & |flag) | (ovfIe & ovfFlag));
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      case (addr)
        A_CTRL:  rdData = CNT_W'(ctrlReg);
        A_STAT:  rdData = CNT_W'({ovfFlag, flag});
        A_CAPA:  rdData = capReg[0];
        A_CAPB:  rdData = capReg[1];
        A_CNT:   rdData = cnt;
        default: rdData = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (wrEn && addr == A_CTRL) ctrlReg <= wrData[CTRL_W-1:0];
  end

  for (genvar g = 0; g < NCH; g++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        flag[g]  <= 1'b0;
        armed[g] <= 1'b0;
      end else begin
        if (capEvt[g])                  flag[g] <= 1'b1;
        else if (armed[g] && capAcc[g]) flag[g] <= 1'b0;
        if (capAcc[g])                  armed[g] <= 1'b0;
        else if (statRd && flag[g])     armed[g] <= 1'b1;
      end
    end

    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      $fell(flag[g]) |-> $past(armed[g] && capAcc[g]));
    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
      $past(capEvt[g]) |-> flag[g]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag  <= 1'b0;
      ovfArmed <= 1'b0;
    end else begin
      if (ovfEvt)                 ovfFlag <= 1'b1;
      else if (ovfArmed && cntRd) ovfFlag <= 1'b0;
      if (cntRd)                  ovfArmed <= 1'b0;
      else if (statRd && ovfFlag) ovfArmed <= 1'b1;
    end
  end

  // R8
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ovfFlag) |-> $past(ovfArmed && cntRd));
  // R9
  alt_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flag[0]) |-> !$past(altMode));
  // R7
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    intMask |-> !irq);
endmodule

// File: rtl/dual_capture_timer.sv
module dual_capture_timer
  import capt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pinA,
  input  logic              pinB,
  input  logic              altMode,
  input  logic              intMask,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wrData,
  output logic [CNT_W-1:0]  rdData,
  output logic              timerIrq
);
  dpCtl_t                    dpCtl;
  logic [CNT_W-1:0]          cnt;
  logic [NCH-1:0][CNT_W-1:0] capReg;
  logic [NCH-1:0]            capEvt;
  logic                      ovfEvt;

  cap_datapath uDp (
    .clk    (clk),
    .rstN   (rstN),
    .pins   ({pinB, pinA}),
    .ctl    (dpCtl),
    .cnt    (cnt),
    .capReg (capReg),
    .capEvt (capEvt),
    .ovfEvt (ovfEvt)
  );

  cap_ctrl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .rdEn    (rdEn),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .altMode (altMode),
    .intMask (intMask),
    .cnt     (cnt),
    .capReg  (capReg),
    .capEvt  (capEvt),
    .ovfEvt  (ovfEvt),
    .dpCtl   (dpCtl),
    .rdData  (rdData),
    .irq     (timerIrq)
  );
endmodule

// File: tb/tb_dual_capture_timer.sv
`timescale 1ns/1ps
module tb_dual_capture_timer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pinA = 1'b0, pinB = 1'b0, altMode = 1'b0, intMask = 1'b0;
  logic       rdEn = 1'b0, wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       timerIrq;
  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  dual_capture_timer dut (
    .clk(clk), .rstN(rstN), .pinA(pinA), .pinB(pinB), .altMode(altMode),
    .intMask(intMask), .rdEn(rdEn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .timerIrq(timerIrq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  // read the counter and change a pin in the same cycle
  task automatic cntAndPin(input int ch, input logic val, output logic [7:0] v);
    @(negedge clk);
    rdEn = 1'b1; addr = 3'd4;
    #1 v = rdData;
    if (ch == 0) pinA = val; else pinB = val;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    busRead(3'd0, d); check("R10 ctrl", d, 8'h00);
    busRead(3'd1, d); check("R10 status", d, 8'h00);
    busRead(3'd2, d); check("R10 capA", d, 8'h00);
    busRead(3'd3, d); check("R10 capB", d, 8'h00);
    check("R10 irq", {7'd0, timerIrq}, 8'h00);
    @(negedge clk); #1 check("R11 idle rdData", rdData, 8'h00);
  endtask

  task automatic testMap();
    logic [7:0] d;
    busWrite(3'd0, 8'hFF);
    busRead(3'd0, d); check("R11 ctrl readback", d, 8'h3F);
    busWrite(3'd0, 8'h00);
  endtask

  task automatic testRate();
    logic [7:0] c0, c1;
    for (int s = 0; s < 4; s++) begin
      busWrite(3'd0, 8'(s << 4));
      busRead(3'd4, c0);
      waitCyc(15);
      busRead(3'd4, c1);
      check($sformatf("R1 rate sel=%0d", s), c1 - c0, 8'(16 >> s));
    end
  endtask

  task automatic testRise();
    logic [7:0] v, d;
    busWrite(3'd0, 8'h01);
    cntAndPin(0, 1'b1, v);
    waitCyc(4);
    busRead(3'd1, d); check("R2 flagA set", {7'd0, d[0]}, 8'h01);
    busRead(3'd2, d); check("R2 capA value", d, v + 8'd2);
    busRead(3'd1, d); check("R5 flagA cleared", {7'd0, d[0]}, 8'h00);
  endtask

  task automatic testFall();
    logic [7:0] v, d;
    @(negedge clk) pinB = 1'b1;
    waitCyc(5);
    busRead(3'd1, d); check("R3 rising ignored flagB", {7'd0, d[1]}, 8'h00);
    busRead(3'd3, d); check("R3 rising ignored capB", d, 8'h00);
    cntAndPin(1, 1'b0, v);
    waitCyc(4);
    busRead(3'd1, d); check("R3 flagB set", {7'd0, d[1]}, 8'h01);
    busRead(3'd3, d); check("R3 capB value", d, v + 8'd2);
  endtask

  task automatic testOverwrite();
    logic [7:0] v1, v2, d;
    @(negedge clk) pinA = 1'b0;
    waitCyc(4);
    cntAndPin(0, 1'b1, v1);
    waitCyc(6);
    @(negedge clk) pinA = 1'b0;
    waitCyc(4);
    cntAndPin(0, 1'b1, v2);
    waitCyc(5);
    busRead(3'd2, d); check("R4 latest capture", d, v2 + 8'd2);
  endtask

  task automatic testTwoStep();
    logic [7:0] d;
    busRead(3'd1, d); check("R5 access without arm keeps flagA", {7'd0, d[0]}, 8'h01);
    busWrite(3'd2, 8'h00);
    busRead(3'd1, d); check("R5 write access clears flagA", {7'd0, d[0]}, 8'h00);
  endtask

  task automatic testCollision();
    logic [7:0] v, d;
    @(negedge clk) pinB = 1'b1;
    waitCyc(4);
    cntAndPin(1, 1'b0, v);
    waitCyc(4);
    @(negedge clk) pinB = 1'b1;
    waitCyc(4);
    busRead(3'd1, d); check("R6 flagB set before", {7'd0, d[1]}, 8'h01);
    @(negedge clk) pinB = 1'b0;
    @(negedge clk);
    busRead(3'd3, d);
    busRead(3'd1, d); check("R6 capture wins over clear", {7'd0, d[1]}, 8'h01);
    busRead(3'd3, d);
    busRead(3'd1, d); check("R6 later clear works", {7'd0, d[1]}, 8'h00);
  endtask

  task automatic testIrq();
    logic [7:0] v, d;
    busWrite(3'd0, 8'h01);
    @(negedge clk) pinA = 1'b0;
    waitCyc(4);
    cntAndPin(0, 1'b1, v);
    waitCyc(5);
    @(negedge clk); #1 check("R7 no irq without enable", {7'd0, timerIrq}, 8'h00);
    intMask = 1'b1;
    busWrite(3'd0, 8'h05);
    @(negedge clk); #1 check("R7 masked", {7'd0, timerIrq}, 8'h00);
    intMask = 1'b0;
    #1 check("R7 pending appears", {7'd0, timerIrq}, 8'h01);
    busRead(3'd1, d);
    busRead(3'd2, d);
    @(negedge clk); #1 check("R7 irq drops after clear", {7'd0, timerIrq}, 8'h00);
    busWrite(3'd0, 8'h00);
  endtask

  task automatic testOverflow();
    logic [7:0] c, d;
    busWrite(3'd0, 8'h08);
    busRead(3'd4, c);
    if (c > 8'hF0) waitCyc(20);
    busRead(3'd1, d);
    busRead(3'd4, d);
    busRead(3'd1, d); check("R8 ovf cleared", {7'd0, d[2]}, 8'h00);
    check("R7 no ovf irq", {7'd0, timerIrq}, 8'h00);
    waitCyc(260);
    @(negedge clk); #1 check("R7 ovf irq", {7'd0, timerIrq}, 8'h01);
    busRead(3'd1, d); check("R8 ovf set", {7'd0, d[2]}, 8'h01);
    busRead(3'd4, d);
    @(negedge clk); #1 check("R8 ovf clear by counter read", {7'd0, timerIrq}, 8'h00);
    busWrite(3'd0, 8'h00);
  endtask

  task automatic testAlt();
    logic [7:0] d;
    busWrite(3'd0, 8'h03);
    @(negedge clk) begin pinA = 1'b0; pinB = 1'b0; end
    waitCyc(4);
    busRead(3'd1, d);
    busRead(3'd2, d);
    busRead(3'd3, d);
    altMode = 1'b1;
    waitCyc(2);
    @(negedge clk) begin pinA = 1'b1; pinB = 1'b1; end
    waitCyc(6);
    busRead(3'd1, d);
    check("R9 chan A ignored", {7'd0, d[0]}, 8'h00);
    check("R9 chan B works", {7'd0, d[1]}, 8'h01);
    altMode = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testMap();
    testRate();
    testRise();
    testFall();
    testOverwrite();
    testTwoStep();
    testCollision();
    testIrq();
    testOverflow();
    testAlt();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule